// File: doc/BRIEF.md
# Five-Stage Multicycle Accumulator Processor

This block is a small 8-bit processor core that runs every instruction through the same fixed walk of states. The walk is: instruction fetch, decode with operand register read, ALU, memory access, and register write-back. The core holds four general-purpose registers, a program counter, a two-byte instruction register and a memory address register. One external synchronous memory serves both code and data. That memory answers a read one clock after the request.

Instructions are two bytes long. The first byte carries the opcode, the destination register index and the source register index. The second byte carries an immediate value or a direct address. The core supports four instructions: load-immediate, load from a direct address, register add, and stop. Each register update is reported on a valid-only write-back stream (`wb_valid`, `wb_reg`, `wb_data`). That stream has no ready signal and so offers no back-pressure: whatever consumes it must take one beat per retired instruction, in the cycle the beat is shown. The memory port is also plain. A request is `mem_rd` with `mem_addr`, and the data must appear on `mem_rdata` in the next cycle, with no stall.

Top module: `quint_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to `pc`=0, `stage`=0 (fetch), `halted`=0 and `wb_valid`=0, and all four registers become 0.
- R2: `stage` reports 0=fetch, 1=decode, 2=ALU, 3=memory, 4=write-back, 5=stopped. A non-stop instruction steps fetch (3 cycles), decode, ALU, memory, write-back, one cycle each, and then returns to fetch. Successive write-back beats are therefore 7 cycles apart, and the first beat comes 6 cycles after reset is released.
- R3: Byte 0 of an instruction holds the opcode in bits 7:4, the destination index in bits 3:2 and the source index in bits 1:0. Byte 1 holds the operand. Fetch reads `pc` and then `pc+1`, and `pc` advances by 2 when decode begins.
- R4: Opcode 0x1 (load-immediate) writes the operand byte into the destination register.
- R5: Opcode 0x2 (load-direct) reads memory in the memory state with `mem_rd`=1 and `mem_addr` equal to the operand. The byte returned is then written into the destination register in write-back.
- R6: Opcode 0x3 (add) writes (destination + source) mod 256 into the destination register. It issues no memory read in the memory state.
- R7: Opcode 0xF, and every opcode other than 0x1–0x3, moves the core from decode to the stopped state. From then on, `halted`=1, `pc` is frozen, and no memory read and no write-back occur until reset.
- R8: `mem_rd` is high only in the first two fetch cycles and in the memory state of load-direct.
- R9: `wb_valid` is high for exactly one cycle per non-stop instruction, only in write-back, with `wb_reg` and `wb_data` giving the register index and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| wb_valid | output | 1 | Register write-back beat |
| wb_reg | output | 2 | Index of the register written |
| wb_data | output | 8 | Value written |
| pc | output | 8 | Program counter |
| stage | output | 3 | Current state code |
| halted | output | 1 | Core stopped |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the register-file read and write of one register: an add whose source and destination are the same register must read its old value and write back double it. The bench provokes this by sweeping all sixteen destination/source pairs, including the four self-adds. The second pair is instruction fetch and data access, which share one memory port: a load-direct aimed at a byte of the program itself must return that code byte. Every write-back beat is judged against an independent interpreter in the bench, for value, register index, `pc` and cycle spacing.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NREG = 4;
  localparam int RIW  = $clog2(NREG);
  localparam int FETCH_LAST = 2;

  localparam logic [3:0] OPC_LDI  = 4'h1;
  localparam logic [3:0] OPC_LDM  = 4'h2;
  localparam logic [3:0] OPC_ADD  = 4'h3;
  localparam logic [3:0] OPC_STOP = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_ALU    = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4,
    ST_STOP   = 3'd5
  } stage_e;

  typedef enum logic [1:0] {
    K_STOP = 2'd0,
    K_LDI  = 2'd1,
    K_LDM  = 2'd2,
    K_ADD  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [RIW-1:0]  dst;
    logic [RIW-1:0]  src;
    logic [DW-1:0]   arg;
  } uop_t;
endpackage

// File: rtl/cpu_sequencer.sv
module cpu_sequencer
  import cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  output stage_e     stage,
  output logic [1:0] fsub
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_FETCH;
      fsub  <= '0;
    end else begin
      case (stage)
        ST_FETCH: begin
          if (fsub == 2'(FETCH_LAST)) begin
            fsub  <= '0;
            stage <= ST_DECODE;
          end else begin
            fsub <= fsub + 2'd1;
          end
        end
        ST_DECODE: stage <= stop_req ? ST_STOP : ST_ALU;
        ST_ALU:    stage <= ST_MEM;
        ST_MEM:    stage <= ST_WB;
        ST_WB:     stage <= ST_FETCH;
        ST_STOP:   stage <= ST_STOP;
        default:   stage <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/cpu_decoder.sv
module cpu_decoder
  import cpu_pkg::*;
(
  input  logic [DW-1:0] ir_op,
  input  logic [DW-1:0] ir_arg,
  output uop_t          uop
);
  always_comb begin
    uop.dst = ir_op[3:2];
    uop.src = ir_op[1:0];
    uop.arg = ir_arg;
    case (ir_op[7:4])
      OPC_LDI: uop.kind = K_LDI;
      OPC_LDM: uop.kind = K_LDM;
      OPC_ADD: uop.kind = K_ADD;
      default: uop.kind = K_STOP;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int N  = NREG,
  parameter int W  = DW,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                             regs[g] <= '0;
      else if (we && waddr == IW'(g))      regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/quint_cpu.sv
module quint_cpu
  import cpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic        mem_rd,
  output logic [7:0]  mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        wb_valid,
  output logic [1:0]  wb_reg,
  output logic [7:0]  wb_data,
  output logic [7:0]  pc,
  output logic [2:0]  stage,
  output logic        halted
);
  stage_e          st;
  logic [1:0]      fsub;
  logic [AW-1:0]   pc_q, mar_q;
  logic [DW-1:0]   ir_op_q, ir_arg_q;
  logic [DW-1:0]   opa_q, opb_q, res_q;
  logic [DW-1:0]   rd_a, rd_b, wdata;
  logic            we;
  uop_t            uop;

  cpu_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .stop_req (uop.kind == K_STOP),
    .stage    (st),
    .fsub     (fsub)
  );

  cpu_decoder u_dec (
    .ir_op  (ir_op_q),
    .ir_arg (ir_arg_q),
    .uop    (uop)
  );

  cpu_regfile #(.N(NREG), .W(DW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (uop.dst),
    .wdata   (wdata),
    .raddr_a (uop.dst),
    .raddr_b (uop.src),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  // Datapath registers, each loaded in its own state.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      mar_q    <= '0;
      ir_op_q  <= '0;
      ir_arg_q <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      res_q    <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          if (fsub == 2'd1) ir_op_q <= mem_rdata;
          if (fsub == 2'(FETCH_LAST)) begin
            ir_arg_q <= mem_rdata;
            pc_q     <= pc_q + AW'(2);
          end
        end
        ST_DECODE: begin
          opa_q <= rd_a;
          opb_q <= rd_b;
        end
        ST_ALU: begin
          res_q <= (uop.kind == K_ADD) ? opa_q + opb_q : uop.arg;
          if (uop.kind == K_LDM) mar_q <= uop.arg[AW-1:0];
        end
        default: ;
      endcase
    end
  end

  // Memory port: two fetch reads, one optional data read.
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = mar_q;
    if (st == ST_FETCH) begin
      mem_addr = (fsub == 2'd0) ? pc_q : pc_q + AW'(1);
      mem_rd   = (fsub != 2'(FETCH_LAST));
    end else if (st == ST_MEM) begin
      mem_rd   = (uop.kind == K_LDM);
    end
  end

  assign we       = (st == ST_WB);
  assign wdata    = (uop.kind == K_LDM) ? mem_rdata : res_q;
  assign wb_valid = we;
  assign wb_reg   = uop.dst;
  assign wb_data  = wdata;
  assign pc       = pc_q;
  assign stage    = st;
  assign halted   = (st == ST_STOP);
endmodule

// File: rtl/quint_cpu_chk.sv
module quint_cpu_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd,
  input logic [7:0] mem_addr,
  input logic [7:0] mem_rdata,
  input logic       wb_valid,
  input logic [1:0] wb_reg,
  input logic [7:0] wb_data,
  input logic [7:0] pc,
  input logic [2:0] stage,
  input logic       halted
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc == 8'd0 && stage == 3'd0 && !halted && !wb_valid)); // R1
  AST_DECODE_NEXT: assert property (@(posedge clk) disable iff (rst) stage == 3'd1 |=> (stage == 3'd2 || stage == 3'd5)); // R2
  AST_ALU_NEXT:    assert property (@(posedge clk) disable iff (rst) stage == 3'd2 |=> stage == 3'd3); // R2
  AST_MEM_NEXT:    assert property (@(posedge clk) disable iff (rst) stage == 3'd3 |=> stage == 3'd4); // R2
  AST_WB_NEXT:     assert property (@(posedge clk) disable iff (rst) stage == 3'd4 |=> stage == 3'd0); // R2
  AST_PC_STEP:     assert property (@(posedge clk) disable iff (rst) (stage == 3'd1 && $past(stage) == 3'd0) |-> pc == 8'($past(pc) + 8'd2)); // R3
  AST_STOP_HOLD:   assert property (@(posedge clk) disable iff (rst) halted |=> (halted && $stable(pc))); // R7
  AST_STOP_QUIET:  assert property (@(posedge clk) disable iff (rst) halted |-> (!mem_rd && !wb_valid)); // R7
  AST_MEM_WINDOW:  assert property (@(posedge clk) disable iff (rst) mem_rd |-> (stage == 3'd0 || stage == 3'd3)); // R8
  AST_WB_ONLY_WB:  assert property (@(posedge clk) disable iff (rst) wb_valid |-> stage == 3'd4); // R9
  AST_WB_SINGLE:   assert property (@(posedge clk) disable iff (rst) wb_valid |=> !wb_valid); // R9
endmodule

bind quint_cpu quint_cpu_chk u_chk (.*);

// File: tb/test_quint_cpu.sv
module test_quint_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_rd;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata;
  logic       wb_valid;
  logic [1:0] wb_reg;
  logic [7:0] wb_data;
  logic [7:0] pc;
  logic [2:0] stage;
  logic       halted;

  always #10 clk = ~clk;

  quint_cpu i_quint_cpu (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_data(wb_data), .pc(pc), .stage(stage), .halted(halted)
  );

  logic [7:0] mem [256];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int total = 0;
  int bad   = 0;
  logic [7:0] bregs [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [3:0] opc, input int d, input int s, input logic [7:0] arg);
    mem[a]   = {opc, 2'(d), 2'(s)};
    mem[a+1] = arg;
  endtask

  function automatic logic [7:0] sweep_val(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h7F;
      4: return 8'h80; 5: return 8'hAA; 6: return 8'hF0; default: return 8'hFF;
    endcase
  endfunction

  task automatic run_prog();
    int  bpc = 0;
    int  gap_exp = 6;
    bit  stop = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == 8'd0, "R1 pc", pc, 0);
    chk(stage == 3'd0, "R1 stage", stage, 0);
    chk(!halted && !wb_valid, "R1 halted/wb", {halted, wb_valid}, 0);
    for (int r = 0; r < 4; r++) bregs[r] = 8'h00;
    rst = 1'b0;
    while (!stop) begin
      logic [3:0] op;
      int d, s, n;
      logic [7:0] arg, expv;
      bit valid, seen;
      string tag;
      op  = mem[bpc][7:4];
      d   = int'(mem[bpc][3:2]);
      s   = int'(mem[bpc][1:0]);
      arg = mem[bpc+1];
      valid = (op == 4'h1 || op == 4'h2 || op == 4'h3);
      case (op)
        4'h1: begin expv = arg;                       tag = "R4"; end
        4'h2: begin expv = mem[arg];                  tag = "R5"; end
        4'h3: begin expv = 8'(bregs[d] + bregs[s]);   tag = "R6"; end
        default: begin expv = 8'h00;                  tag = "R7"; end
      endcase
      n = 0; seen = 0;
      while (!seen && n < 20) begin
        @(negedge clk); n++;
        if (valid && stage == 3'd3) begin
          chk(mem_rd == (op == 4'h2), "R8 mem-state read", mem_rd, op == 4'h2);
          if (op == 4'h2) chk(mem_addr == arg, "R5 direct addr", mem_addr, arg);
        end
        if (valid && wb_valid) seen = 1;
        if (!valid && halted) seen = 1;
      end
      if (valid) begin
        chk(n == gap_exp, "R2 R9 beat spacing", n, gap_exp);
        chk(wb_reg == 2'(d), {tag, " dest"}, wb_reg, d);
        chk(wb_data == expv, {tag, " value"}, wb_data, expv);
        chk(pc == 8'(bpc + 2), "R3 pc step", pc, 8'(bpc + 2));
        bregs[d] = expv;
        bpc += 2;
        gap_exp = 7;
        if (bpc >= 254) stop = 1;
      end else begin
        chk(n == gap_exp - 2, "R7 stop timing", n, gap_exp - 2);
        for (int k = 0; k < 10; k++) begin
          @(negedge clk);
          chk(halted && pc == 8'(bpc + 2), "R7 frozen", pc, 8'(bpc + 2));
          chk(!wb_valid && !mem_rd, "R7 R8 quiet", {wb_valid, mem_rd}, 0);
        end
        stop = 1;
      end
    end
  endtask

  initial begin
    int a;
    // Program A: loads, full add-pair sweep, direct loads incl. a code byte.
    clear_mem();
    a = 0;
    put(a, 4'h1, 0, 0, 8'h11); a += 2;
    put(a, 4'h1, 1, 0, 8'h22); a += 2;
    put(a, 4'h1, 2, 0, 8'h93); a += 2;
    put(a, 4'h1, 3, 0, 8'hFE); a += 2;
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) begin
        put(a, 4'h3, d, s, 8'h00); a += 2;
      end
    for (int r = 0; r < 4; r++) begin
      mem[8'hC0 + r] = 8'(8'h5A + r * 8'h11);
      put(a, 4'h2, r, 0, 8'(8'hC0 + r)); a += 2;
    end
    put(a, 4'h2, 0, 0, 8'h01); a += 2;
    put(a, 4'h3, 0, 3, 8'h00); a += 2;
    put(a, 4'hF, 0, 0, 8'h00);
    run_prog();
    // Sweep: operand pairs, register pairs and every stopping opcode.
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        int k;
        logic [3:0] sop;
        k = (i * 8 + j) % 13;
        sop = (k == 0) ? 4'h0 : 4'(k + 3);
        clear_mem();
        put(0, 4'h1, i % 4, 0, sweep_val(i));
        put(2, 4'h1, j % 4, 0, sweep_val(j));
        put(4, 4'h3, i % 4, j % 4, 8'h00);
        put(6, sop, 0, 0, 8'h00);
        run_prog();
      end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule